// File: doc/BRIEF.md
# RTC Watchdog Timer with Selectable Time Base

This block is the watchdog of a real-time clock. It is configured and kept alive through one byte-wide register at bus address 0x09. A single write to that register sets the timeout and restarts the countdown. Writing a value that does not describe a valid timeout stops the watchdog.

The timeout is a 5-bit multiplier times a time base. The time base is either the 1 Hz tick or the 0.25 Hz tick, and both ticks are supplied as single-cycle enables from elsewhere. The 4-second base reaches timeouts of up to about two minutes.

When the countdown runs out, the block sets a sticky watchdog flag and drives a reset pulse of fixed length. It then stays idle until software writes the register again. A parameter selects the variant with a 3-bit resolution field, in which the top register bit becomes part of the resolution code.

Top module: `rtc_wdog`

## Requirements
- R1: While reset is asserted and after it is released, `cfg_o` is 0x00, `wdog_flag_o` is 0 and `wdog_rst_o` is 0.
- R2: A write with `addr_i` equal to 0x09 stores `wdata_i`, and `cfg_o` shows that byte from the next cycle on. A write to any other address leaves `cfg_o` unchanged.
- R3: With resolution bits [1:0] = 2 and multiplier bits [6:2] = M (1..31), expiry occurs on the M-th `tick_1s_i` pulse after the write, and `tick_4s_i` has no effect.
- R4: With resolution bits [1:0] = 3 and multiplier M, expiry occurs on the M-th `tick_4s_i` pulse after the write, and `tick_1s_i` has no effect.
- R5: Every write of a valid configuration reloads the countdown to M, so it acts as the keep-alive.
- R6: Writing 0x00 stops a running countdown, and no expiry follows.
- R7: A multiplier of 0 leaves the watchdog stopped, whatever the resolution bits are.
- R8: Expiry sets `wdog_flag_o`, which stays at 1 until reset, even across later writes.
- R9: On expiry `wdog_rst_o` is high for exactly RST_CYC cycles (default 8), starting in the cycle after the expiring tick. The watchdog then stays stopped until it is rewritten, so further ticks give no second pulse.
- R10: In the default variant, resolution codes 0 and 1 leave the watchdog stopped. Bit 7 is stored and read back but does not affect timing. In the variant with a 3-bit resolution field, a 1 in bit 7 makes the code invalid, and the watchdog stays stopped.
- R11: When a register write and a tick fall in the same cycle, the write wins: the count is reloaded and that tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register address of the write |
| wdata_i | input | 8 | Write data |
| tick_1s_i | input | 1 | One-cycle enable, once per second |
| tick_4s_i | input | 1 | One-cycle enable, once every four seconds |
| cfg_o | output | 8 | Last value written to the watchdog register |
| wdog_flag_o | output | 1 | Sticky expiry flag |
| wdog_rst_o | output | 1 | Reset pulse driven on expiry |

## Verification
The pulse-length property assumes that a second expiry never lands while a reset pulse is still running. Such an expiry would need a rewrite and a tick within RST_CYC cycles of the first one. The bench never rewrites or ticks until the pulse has been counted out.

The stimulus drives each tick as a single-cycle enable, as the upstream divider would. It sweeps every multiplier under both time bases, with ticks of the other base interleaved. It also places a write and a tick in the same cycle on purpose, to exercise the ordering rule.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CFG_W    = 8;
  localparam int MULT_LSB = 2;
  localparam int MULT_W   = 5;

  typedef enum logic [1:0] {
    BASE_NONE = 2'd0,
    BASE_1S   = 2'd1,
    BASE_4S   = 2'd2
  } base_e;

  // wide=1: bit 7 joins the resolution code, so a set bit 7 is invalid
  function automatic base_e decode_base(input logic [CFG_W-1:0] v, input logic wide);
    logic [2:0] code;
    code = {v[7] & wide, v[1:0]};
    if (v[MULT_LSB +: MULT_W] == '0) return BASE_NONE;
    case (code)
      3'b010:  return BASE_1S;
      3'b011:  return BASE_4S;
      default: return BASE_NONE;
    endcase
  endfunction
endpackage

// File: rtl/wdog_cfg_reg.sv
module wdog_cfg_reg
  import wdog_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter logic [7:0]  REG_ADDR = 8'h09,
  parameter bit          WIDE_RES = 1'b0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [CFG_W-1:0]    wdata_i,
  output logic [CFG_W-1:0]    cfg_o,
  output logic                load_o,
  output logic [MULT_W-1:0]   load_mult_o,
  output base_e               load_base_o,
  output base_e               run_base_o
);
  logic [CFG_W-1:0] cfg_q;
  logic             hit;

  assign hit = wr_en_i && (addr_i == ADDR_W'(REG_ADDR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  cfg_q <= '0;
    else if (hit) cfg_q <= wdata_i;
  end

  assign cfg_o       = cfg_q;
  assign load_o      = hit;
  assign load_mult_o = wdata_i[MULT_LSB +: MULT_W];
  assign load_base_o = decode_base(wdata_i, WIDE_RES);
  assign run_base_o  = decode_base(cfg_q, WIDE_RES);
endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown
  import wdog_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [MULT_W-1:0] load_mult_i,
  input  base_e             load_base_i,
  input  base_e             run_base_i,
  input  logic              tick_1s_i,
  input  logic              tick_4s_i,
  output logic              expire_o
);
  logic [MULT_W-1:0] cnt_q;
  logic              armed_q;
  logic              step;

  assign step = (run_base_i == BASE_1S && tick_1s_i) ||
                (run_base_i == BASE_4S && tick_4s_i);

  // load has priority over a coincident tick
  assign expire_o = armed_q && step && !load_i && (cnt_q == MULT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (load_i) begin
      cnt_q   <= load_mult_i;
      armed_q <= (load_base_i != BASE_NONE);
    end else if (armed_q && step) begin
      cnt_q <= cnt_q - MULT_W'(1);
      if (cnt_q == MULT_W'(1)) armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/wdog_pulse_gen.sv
module wdog_pulse_gen #(
  parameter int RST_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  output logic flag_o,
  output logic pulse_o
);
  localparam int PW = $clog2(RST_CYC + 1);

  logic [PW-1:0] pcnt_q;
  logic          flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (expire_i) flag_q <= 1'b1;
      if (expire_i)           pcnt_q <= PW'(RST_CYC);
      else if (pcnt_q != '0)  pcnt_q <= pcnt_q - PW'(1);
    end
  end

  assign flag_o  = flag_q;
  assign pulse_o = (pcnt_q != '0);
endmodule

// File: rtl/rtc_wdog.sv
module rtc_wdog
  import wdog_pkg::*;
#(
  parameter int         ADDR_W   = 8,
  parameter logic [7:0] REG_ADDR = 8'h09,
  parameter bit         WIDE_RES = 1'b0,
  parameter int         RST_CYC  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              tick_1s_i,
  input  logic              tick_4s_i,
  output logic [7:0]        cfg_o,
  output logic              wdog_flag_o,
  output logic              wdog_rst_o
);
  logic              load;
  logic [MULT_W-1:0] load_mult;
  base_e             load_base;
  base_e             run_base;
  logic              expire;

  wdog_cfg_reg #(
    .ADDR_W  (ADDR_W),
    .REG_ADDR(REG_ADDR),
    .WIDE_RES(WIDE_RES)
  ) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .cfg_o      (cfg_o),
    .load_o     (load),
    .load_mult_o(load_mult),
    .load_base_o(load_base),
    .run_base_o (run_base)
  );

  wdog_countdown u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_mult_i(load_mult),
    .load_base_i(load_base),
    .run_base_i (run_base),
    .tick_1s_i  (tick_1s_i),
    .tick_4s_i  (tick_4s_i),
    .expire_o   (expire)
  );

  wdog_pulse_gen #(.RST_CYC(RST_CYC)) u_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .expire_i(expire),
    .flag_o  (wdog_flag_o),
    .pulse_o (wdog_rst_o)
  );
endmodule

// File: rtl/rtc_wdog_chk.sv
module rtc_wdog_chk #(
  parameter int         ADDR_W   = 8,
  parameter logic [7:0] REG_ADDR = 8'h09,
  parameter int         RST_CYC  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        wdata_i,
  input logic [7:0]        cfg_o,
  input logic              wdog_flag_o,
  input logic              wdog_rst_o
);
  localparam int LW = $clog2(RST_CYC + 2);

  logic          hit;
  logic [LW-1:0] hi_len;

  assign hit = wr_en_i && (addr_i == ADDR_W'(REG_ADDR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               hi_len <= '0;
    else if (!wdog_rst_o)                      hi_len <= '0;
    else if (hi_len != LW'(RST_CYC + 1))       hi_len <= hi_len + LW'(1);
  end

  AST_CFG_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> cfg_o == $past(wdata_i)); // R2
  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |=> $stable(cfg_o)); // R2
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdog_flag_o |=> wdog_flag_o); // R8
  AST_FLAG_WITH_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdog_flag_o) |-> $rose(wdog_rst_o)); // R8
  AST_PULSE_FLAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdog_rst_o |-> wdog_flag_o); // R9
  AST_PULSE_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdog_rst_o |-> hi_len < LW'(RST_CYC)); // R9
  AST_ZERO_MULT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && wdata_i[6:2] == 5'd0) |=> !$rose(wdog_rst_o)); // R7
  AST_RUN_NEEDS_MULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdog_rst_o) |-> $past(cfg_o[6:2]) != 5'd0); // R6
endmodule

bind rtc_wdog rtc_wdog_chk #(
  .ADDR_W  (ADDR_W),
  .REG_ADDR(REG_ADDR),
  .RST_CYC (RST_CYC)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .cfg_o      (cfg_o),
  .wdog_flag_o(wdog_flag_o),
  .wdog_rst_o (wdog_rst_o)
);

// File: tb/rtc_wdog_test.sv
module rtc_wdog_test;
  localparam int RST_CYC = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       t1 = 1'b0;
  logic       t4 = 1'b0;
  logic [7:0] cfg;
  logic       flag;
  logic       wrst;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  rtc_wdog #(.RST_CYC(RST_CYC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .tick_1s_i(t1), .tick_4s_i(t4), .cfg_o(cfg), .wdog_flag_o(flag), .wdog_rst_o(wrst)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 0; t1 = 0; t4 = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wreg(input logic [7:0] a, input logic [7:0] d, input logic k1 = 0);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d; t1 = k1;
    @(negedge clk);
    wr_en = 0; t1 = 0;
  endtask

  task automatic tick(input bit four);
    @(negedge clk);
    t1 = !four; t4 = four;
    @(negedge clk);
    t1 = 0; t4 = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_len(output int n);
    n = 0;
    while (wrst && n < 40) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog: run did not complete, actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    bit early;

    // R1 reset state, also while held
    #1;
    check(cfg == 8'h00 && !flag && !wrst, "R1 during reset", {cfg, flag, wrst}, 0);
    do_reset();
    check(cfg == 8'h00 && !flag && !wrst, "R1 after reset", {cfg, flag, wrst}, 0);

    // R2 load and address decode
    wreg(8'h09, 8'h5A);
    check(cfg == 8'h5A, "R2 write", cfg, 8'h5A);
    wreg(8'h08, 8'h33);
    check(cfg == 8'h5A, "R2 other address", cfg, 8'h5A);
    wreg(8'h89, 8'h11);
    check(cfg == 8'h5A, "R2 aliased address", cfg, 8'h5A);

    // R3 / R4 sweep: every multiplier on both bases
    for (int r = 2; r <= 3; r++) begin
      for (int m = 1; m <= 31; m++) begin
        do_reset();
        wreg(8'h09, {1'b0, 5'(m), 2'(r)});
        early = 0;
        for (int i = 0; i < m - 1; i++) begin
          tick(r == 2);            // wrong base, must be ignored
          tick(r == 3);
          if (flag || wrst) early = 1;
        end
        tick(r == 2);
        if (flag || wrst) early = 1;
        check(!early, r == 2 ? "R3 no early expiry" : "R4 no early expiry", early, 0);
        tick(r == 3);
        check(flag && wrst, r == 2 ? "R3 expiry" : "R4 expiry", {flag, wrst}, 3);
        pulse_len(n);
        check(n == RST_CYC, "R9 pulse length", n, RST_CYC);
      end
    end

    // R5 keep-alive
    do_reset();
    wreg(8'h09, {1'b0, 5'd3, 2'd2});
    tick(0); tick(0);
    wreg(8'h09, {1'b0, 5'd3, 2'd2});
    tick(0); tick(0);
    check(!flag && !wrst, "R5 reload held off expiry", flag, 0);
    tick(0);
    check(flag && wrst, "R5 expiry after reload", {flag, wrst}, 3);

    // R8 / R9 sticky flag, no second pulse, stopped until rewrite
    idle(RST_CYC + 2);
    check(flag && !wrst, "R8 flag sticky after pulse", {flag, wrst}, 2);
    n = 0;
    for (int i = 0; i < 6; i++) begin
      tick(0);
      if (wrst) n++;
    end
    check(n == 0, "R9 stopped after expiry", n, 0);
    wreg(8'h09, 8'h00);
    check(flag, "R8 flag survives write", flag, 1);

    // R6 stop by writing zero
    do_reset();
    wreg(8'h09, {1'b0, 5'd2, 2'd2});
    tick(0);
    wreg(8'h09, 8'h00);
    n = 0;
    for (int i = 0; i < 40; i++) begin
      tick(0); tick(1);
      if (flag || wrst) n++;
    end
    check(n == 0, "R6 zero write stops", n, 0);

    // R7 zero multiplier on either resolution
    for (int r = 0; r < 4; r++) begin
      do_reset();
      wreg(8'h09, {6'd0, 2'(r)});
      n = 0;
      for (int i = 0; i < 5; i++) begin
        tick(0); tick(1);
        if (flag || wrst) n++;
      end
      check(n == 0, "R7 zero multiplier", n, 0);
    end

    // R10 invalid codes and bit 7 in the default variant
    for (int r = 0; r < 2; r++) begin
      do_reset();
      wreg(8'h09, {1'b0, 5'd1, 2'(r)});
      n = 0;
      for (int i = 0; i < 5; i++) begin
        tick(0); tick(1);
        if (flag || wrst) n++;
      end
      check(n == 0, "R10 invalid resolution", n, 0);
    end
    do_reset();
    wreg(8'h09, {1'b1, 5'd2, 2'd2});
    check(cfg == 8'h8A, "R10 bit 7 readback", cfg, 8'h8A);
    tick(0);
    check(!flag, "R10 bit 7 no early expiry", flag, 0);
    tick(0);
    check(flag && wrst, "R10 bit 7 ignored for timing", {flag, wrst}, 3);

    // R11 write and tick in the same cycle
    do_reset();
    wreg(8'h09, {1'b0, 5'd1, 2'd2});
    wreg(8'h09, {1'b0, 5'd1, 2'd2}, 1'b1);
    check(!flag && !wrst, "R11 write wins over tick", flag, 0);
    tick(0);
    check(flag && wrst, "R11 expiry on next tick", {flag, wrst}, 3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule